// File: doc/BRIEF.md
# Deficit Round Robin Scheduler

This block shares one output link among several flow queues with the deficit round robin discipline. The packet buffers live outside it: for every flow it sees only a backlog flag and the byte length of the packet at the head of that queue. It answers with dequeue commands, one packet at a time. Each command names the flow and the length of the packet to take. A quantum table, one entry per flow and set in proportion to the flow's weight, fixes how many bytes each flow may send per round.

Each flow has a byte deficit counter. When the scheduler reaches a backlogged flow, it adds that flow's quantum once. It then sends head packets while each one fits in what remains of the counter. If a packet does not fit, the remainder is kept for the next round. If the queue runs dry during the visit, the counter is cleared. Empty queues are passed over in a single cycle, so the cost per packet does not grow with the number of idle flows.

The environment must pop the head of the named queue at the clock edge that ends the one-cycle dequeue pulse. The new head length and backlog flag must be valid from the following cycle.

Top module: `drr_sched`

## Requirements
- R1: While reset is high and in the cycle after it falls, `deq_valid` is 0. Every deficit counter starts at 0.
- R2: Flows are visited in ascending index order with wraparound. The search starts at the flow after the last one visited, or at flow 0 after reset. With at least one flow backlogged, the next one is found in one cycle however many empty flows lie between.
- R3: On entering a visit to flow i, its deficit grows by its quantum (bits [i*QNT_W +: QNT_W] of `quantum_flat`) exactly once.
- R4: A dequeue is issued only when the head length is less than or equal to the current deficit, equality included. The deficit then drops by that length.
- R5: When the head length exceeds the deficit, the visit ends without a dequeue. The deficit is kept for the next round and the search moves on to the next index.
- R6: When the visited flow's queue is empty, its deficit is forced to 0 and the search moves on.
- R7: In a cycle where no flow is backlogged, no dequeue is issued in the next cycle.
- R8: `deq_valid` is high for exactly one cycle per packet and is always followed by at least one low cycle.
- R9: While `deq_valid` is high, `deq_flow` names a backlogged flow. `deq_len` equals that flow's head length, bits [f*LEN_W +: LEN_W] of `head_len_flat`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| q_nonempty | input | NUM_FLOWS | Bit i high when flow i has a packet waiting |
| head_len_flat | input | NUM_FLOWS*LEN_W | Head packet length in bytes, one field per flow |
| quantum_flat | input | NUM_FLOWS*QNT_W | Per-flow quantum in bytes, one field per flow |
| deq_valid | output | 1 | One-cycle dequeue command |
| deq_flow | output | IDX_W | Flow to pop |
| deq_len | output | LEN_W | Length of the packet popped |

## Verification
A reference model in the bench replays the deficit rules over the loaded queues. The predicted sequence of flow and length pairs is compared with the dequeues as they appear. Packets exactly equal to the quantum are set against packets one byte longer, which separates the less-or-equal test from a strict one. Packets several quanta long, mixed with short ones on other flows, expose lost or double-added quanta through the interleaving they produce. A flow left with remaining credit just before its queue runs dry, and then refilled beside a busy neighbour, shows whether the counter was cleared. A single backlogged flow surrounded by empty ones checks the wraparound search order.

// File: rtl/drr_pkg.sv
`timescale 1ns/1ps
package drr_pkg;
  // Controller phases: search for a backlogged flow, serve it, let the
  // external queue settle after a pop.
  typedef enum logic [1:0] {
    ST_SCAN  = 2'd0,
    ST_SERVE = 2'd1,
    ST_WAIT  = 2'd2
  } drr_state_e;
endpackage

// File: rtl/drr_rr_pick.sv
`timescale 1ns/1ps
// Rotating first-one finder: lowest set request at or after base, wrapping.
module drr_rr_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] base,
  output logic          found,
  output logic [IW-1:0] pick
);
  logic [2*N-1:0] dbl;
  logic [2*N-1:0] shf;
  logic [N-1:0]   rot;
  logic [IW:0]    off;
  logic [IW:0]    sum;

  always_comb begin
    dbl   = {req, req};
    shf   = dbl >> base;
    rot   = shf[N-1:0];
    found = |req;
    off   = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (rot[k]) off = (IW+1)'(k);
    end
    sum = {1'b0, base} + off;
    if (sum >= (IW+1)'(N)) sum = sum - (IW+1)'(N);
    pick = sum[IW-1:0];
  end
endmodule

// File: rtl/drr_deficit_bank.sv
`timescale 1ns/1ps
// Per-flow deficit storage: one write port, one read port, no reset on the
// array itself so it can map to distributed RAM. A valid bit per entry makes
// never-written entries read as zero.
module drr_deficit_bank #(
  parameter int N  = 4,
  parameter int DW = 13,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data
);
  logic [DW-1:0] mem [0:N-1];
  logic [N-1:0]  vld;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) vld <= '0;
    else if (wr_en) vld[wr_idx] <= 1'b1;
  end

  assign rd_data = vld[rd_idx] ? mem[rd_idx] : '0;
endmodule

// File: rtl/drr_ctrl.sv
`timescale 1ns/1ps
// Visit controller: adds quantum on entry, pops fitting head packets,
// clears credit when the queue runs dry, and moves the pointer on.
module drr_ctrl
  import drr_pkg::*;
#(
  parameter int N  = 4,
  parameter int LW = 12,
  parameter int QW = 12,
  parameter int DW = 13,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  q_nonempty,
  input  logic          found,
  input  logic [IW-1:0] pick,
  input  logic [LW-1:0] cur_head,
  input  logic [QW-1:0] cur_qnt,
  input  logic [DW-1:0] cur_def,
  output drr_state_e    st,
  output logic [IW-1:0] ptr,
  output logic          wr_en,
  output logic [DW-1:0] wr_data,
  output logic          deq_valid,
  output logic [IW-1:0] deq_flow,
  output logic [LW-1:0] deq_len
);
  drr_state_e    st_d;
  logic [IW-1:0] ptr_d;
  logic [IW-1:0] ptr_inc;
  logic [DW-1:0] head_ext;
  logic [DW-1:0] qnt_ext;
  logic          head_fits;
  logic          issue;

  always_comb begin
    ptr_inc   = (ptr == IW'(N - 1)) ? '0 : ptr + IW'(1);
    head_ext  = DW'(cur_head);
    qnt_ext   = DW'(cur_qnt);
    head_fits = (head_ext <= cur_def);
    st_d      = st;
    ptr_d     = ptr;
    wr_en     = 1'b0;
    wr_data   = '0;
    issue     = 1'b0;
    case (st)
      ST_SCAN: begin
        if (found) begin
          ptr_d   = pick;
          wr_en   = 1'b1;
          wr_data = cur_def + qnt_ext;
          st_d    = ST_SERVE;
        end
      end
      ST_SERVE: begin
        if (!q_nonempty[ptr]) begin
          wr_en   = 1'b1;
          wr_data = '0;
          ptr_d   = ptr_inc;
          st_d    = ST_SCAN;
        end else if (head_fits) begin
          wr_en   = 1'b1;
          wr_data = cur_def - head_ext;
          issue   = 1'b1;
          st_d    = ST_WAIT;
        end else begin
          ptr_d = ptr_inc;
          st_d  = ST_SCAN;
        end
      end
      ST_WAIT: st_d = ST_SERVE;
      default: st_d = ST_SCAN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_SCAN;
      ptr       <= '0;
      deq_valid <= 1'b0;
      deq_flow  <= '0;
      deq_len   <= '0;
    end else begin
      st        <= st_d;
      ptr       <= ptr_d;
      deq_valid <= issue;
      if (issue) begin
        deq_flow <= ptr;
        deq_len  <= cur_head;
      end
    end
  end
endmodule

// File: rtl/drr_sched.sv
`timescale 1ns/1ps
module drr_sched
  import drr_pkg::*;
#(
  parameter int NUM_FLOWS = 4,
  parameter int LEN_W     = 12,
  parameter int QNT_W     = 12,
  parameter int IDX_W     = (NUM_FLOWS > 1) ? $clog2(NUM_FLOWS) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_FLOWS-1:0]       q_nonempty,
  input  logic [NUM_FLOWS*LEN_W-1:0] head_len_flat,
  input  logic [NUM_FLOWS*QNT_W-1:0] quantum_flat,
  output logic                       deq_valid,
  output logic [IDX_W-1:0]           deq_flow,
  output logic [LEN_W-1:0]           deq_len
);
  // Leftover credit stays below the head length, so one extra bit over the
  // wider of length and quantum always holds credit plus quantum.
  localparam int DEF_W = ((LEN_W > QNT_W) ? LEN_W : QNT_W) + 1;

  logic [LEN_W-1:0] head_arr [0:NUM_FLOWS-1];
  logic [QNT_W-1:0] qnt_arr  [0:NUM_FLOWS-1];

  genvar g;
  generate
    for (g = 0; g < NUM_FLOWS; g++) begin : g_slice
      assign head_arr[g] = head_len_flat[g*LEN_W +: LEN_W];
      assign qnt_arr[g]  = quantum_flat[g*QNT_W +: QNT_W];
    end
  endgenerate

  drr_state_e       st;
  logic [IDX_W-1:0] ptr;
  logic [IDX_W-1:0] pick;
  logic             found;
  logic [IDX_W-1:0] tbl_idx;
  logic [DEF_W-1:0] cur_def;
  logic [LEN_W-1:0] cur_head;
  logic [QNT_W-1:0] cur_qnt;
  logic             wr_en;
  logic [DEF_W-1:0] wr_data;

  assign tbl_idx  = (st == ST_SCAN) ? pick : ptr;
  assign cur_head = head_arr[ptr];
  assign cur_qnt  = qnt_arr[pick];

  drr_rr_pick #(.N(NUM_FLOWS), .IW(IDX_W)) u_pick (
    .req   (q_nonempty),
    .base  (ptr),
    .found (found),
    .pick  (pick)
  );

  drr_deficit_bank #(.N(NUM_FLOWS), .DW(DEF_W), .IW(IDX_W)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .rd_idx  (tbl_idx),
    .rd_data (cur_def),
    .wr_en   (wr_en),
    .wr_idx  (tbl_idx),
    .wr_data (wr_data)
  );

  drr_ctrl #(
    .N(NUM_FLOWS), .LW(LEN_W), .QW(QNT_W), .DW(DEF_W), .IW(IDX_W)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .q_nonempty (q_nonempty),
    .found      (found),
    .pick       (pick),
    .cur_head   (cur_head),
    .cur_qnt    (cur_qnt),
    .cur_def    (cur_def),
    .st         (st),
    .ptr        (ptr),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .deq_valid  (deq_valid),
    .deq_flow   (deq_flow),
    .deq_len    (deq_len)
  );
endmodule

// File: rtl/drr_sched_chk.sv
`timescale 1ns/1ps
module drr_sched_chk
  import drr_pkg::*;
#(
  parameter int N  = 4,
  parameter int LW = 12,
  parameter int DW = 13,
  parameter int IW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic [N-1:0]  q_nonempty,
  input logic [N*LW-1:0] head_len_flat,
  input logic          deq_valid,
  input logic [IW-1:0] deq_flow,
  input logic [LW-1:0] deq_len,
  input logic [1:0]    st,
  input logic [IW-1:0] ptr,
  input logic [DW-1:0] cur_def,
  input logic [LW-1:0] cur_head
);
  assert_rst_quiet_R1: assert property (@(posedge clk) rst |=> !deq_valid);

  assert_scan_one_cycle_R2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SCAN && q_nonempty != '0) |=> (st == ST_SERVE));

  assert_deq_fits_R4: assert property (@(posedge clk) disable iff (rst)
    deq_valid |-> (DW'(deq_len) <= $past(cur_def)));

  assert_too_long_R5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SERVE && q_nonempty[ptr] && DW'(cur_head) > cur_def)
      |=> (st == ST_SCAN && !deq_valid));

  assert_empty_leave_R6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SERVE && !q_nonempty[ptr]) |=> (st == ST_SCAN && !deq_valid));

  assert_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (q_nonempty == '0) |=> !deq_valid);

  assert_deq_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    deq_valid |=> !deq_valid);

  assert_deq_head_R9: assert property (@(posedge clk) disable iff (rst)
    deq_valid |-> (q_nonempty[deq_flow] &&
                   head_len_flat[deq_flow*LW +: LW] == deq_len));
endmodule

bind drr_sched drr_sched_chk #(
  .N(NUM_FLOWS), .LW(LEN_W), .DW(DEF_W), .IW(IDX_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .q_nonempty    (q_nonempty),
  .head_len_flat (head_len_flat),
  .deq_valid     (deq_valid),
  .deq_flow      (deq_flow),
  .deq_len       (deq_len),
  .st            (st),
  .ptr           (ptr),
  .cur_def       (cur_def),
  .cur_head      (cur_head)
);

// File: tb/drr_sched_tb_top.sv
`timescale 1ns/1ps
module drr_sched_tb_top;
  localparam int N  = 4;
  localparam int LW = 12;
  localparam int QW = 12;
  localparam int IW = 2;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [N-1:0]    q_ne = '0;
  logic [N*LW-1:0] head_flat = '0;
  logic [N*QW-1:0] qnt_flat = '0;
  logic            deq_valid;
  logic [IW-1:0]   deq_flow;
  logic [LW-1:0]   deq_len;

  always #2 clk = ~clk;

  drr_sched #(.NUM_FLOWS(N), .LEN_W(LW), .QNT_W(QW)) dut_i (
    .clk           (clk),
    .rst           (rst),
    .q_nonempty    (q_ne),
    .head_len_flat (head_flat),
    .quantum_flat  (qnt_flat),
    .deq_valid     (deq_valid),
    .deq_flow      (deq_flow),
    .deq_len       (deq_len)
  );

  typedef struct { int f; int l; } exp_t;

  int    eq [N][$];   // environment queues feeding the design
  int    mq [N][$];   // model copy of the same contents
  exp_t  expq [$];
  int    qnt [N];
  int    m_def [N];
  int    m_ptr;
  int    checks;
  int    errors;
  bit    done;
  bit    prev_valid;
  string cur_req;

  // Environment: pop on the edge ending a dequeue pulse, present new heads.
  always @(posedge clk) begin
    if (!rst && deq_valid && eq[deq_flow].size() > 0) void'(eq[deq_flow].pop_front());
    for (int i = 0; i < N; i++) begin
      q_ne[i] <= (eq[i].size() > 0);
      head_flat[i*LW +: LW] <= (eq[i].size() > 0) ? LW'(eq[i][0]) : '0;
    end
  end

  // Monitor: scoreboard compare of every dequeue.
  always @(negedge clk) begin
    exp_t e;
    if (!rst && deq_valid) begin
      checks++;
      if (prev_valid) begin
        errors++;
        $display("FAIL R8: deq_valid high in consecutive cycles, actual 1 expected 0");
      end
      checks++;
      if (expq.size() == 0) begin
        errors++;
        $display("FAIL %s: unexpected dequeue flow %0d len %0d, expected none",
                 cur_req, deq_flow, deq_len);
      end else begin
        e = expq.pop_front();
        if (e.f != int'(deq_flow) || e.l != int'(deq_len)) begin
          errors++;
          $display("FAIL %s: dequeue actual flow %0d len %0d expected flow %0d len %0d",
                   cur_req, deq_flow, deq_len, e.f, e.l);
        end
      end
    end
    prev_valid = deq_valid;
  end

  task automatic check_eq(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_q(int f, int v);
    qnt[f] = v;
    qnt_flat[f*QW +: QW] = QW'(v);
  endtask

  task automatic push(int f, int l);
    eq[f].push_back(l);
    mq[f].push_back(l);
  endtask

  // Reference deficit round robin over the model queues.
  task automatic model_run();
    bit any;
    int f;
    exp_t e;
    any = 1'b1;
    while (any) begin
      any = 1'b0;
      for (int i = 0; i < N; i++) if (mq[i].size() > 0) any = 1'b1;
      if (any) begin
        f = m_ptr;
        for (int k = 0; k < N; k++) begin
          if (mq[(m_ptr + k) % N].size() > 0) begin
            f = (m_ptr + k) % N;
            break;
          end
        end
        m_def[f] += qnt[f];
        while (mq[f].size() > 0 && mq[f][0] <= m_def[f]) begin
          e.f = f;
          e.l = mq[f][0];
          expq.push_back(e);
          m_def[f] -= mq[f][0];
          void'(mq[f].pop_front());
        end
        if (mq[f].size() == 0) m_def[f] = 0;
        m_ptr = (f + 1) % N;
      end
    end
  endtask

  task automatic run_scn(string req);
    int t;
    cur_req = req;
    model_run();
    t = 0;
    while (expq.size() != 0 && t < 4000) begin
      @(negedge clk);
      t++;
    end
    repeat (8) @(negedge clk);
    check_eq(req, expq.size(), 0, "outstanding expected dequeues");
  endtask

  initial begin
    checks = 0;
    errors = 0;
    done = 1'b0;
    prev_valid = 1'b0;
    m_ptr = 0;
    cur_req = "R1";
    for (int i = 0; i < N; i++) begin
      qnt[i] = 0;
      m_def[i] = 0;
    end

    // R1: quiet during and right after reset
    repeat (4) @(negedge clk);
    check_eq("R1", int'(deq_valid), 0, "deq_valid in reset");
    rst = 1'b0;
    @(negedge clk);
    check_eq("R1", int'(deq_valid), 0, "deq_valid after reset");

    // R7: nothing backlogged, nothing issued
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (c % 5 == 0) check_eq("R7", int'(deq_valid), 0, "deq_valid while idle");
    end

    // R3/R4: quantum added once, equal length fits, one byte over waits
    for (int i = 0; i < N; i++) set_q(i, 100);
    push(0, 100);
    push(1, 101);
    push(2, 40); push(2, 60);
    run_scn("R3/R4 equality and first-round credit");

    // R5/R2: long packets span rounds, interleaving order
    set_q(0, 50); set_q(1, 200); set_q(2, 50); set_q(3, 100);
    push(0, 120); push(0, 30);
    push(1, 500); push(1, 80);
    push(3, 90); push(3, 90); push(3, 90);
    run_scn("R5/R2 multi-round carry");

    // R6: leftover credit cleared when the queue empties
    set_q(0, 100); set_q(1, 50); set_q(2, 100); set_q(3, 100);
    push(0, 30);
    run_scn("R6 credit left before empty");
    @(negedge clk);
    push(0, 150);
    push(1, 50); push(1, 50); push(1, 50);
    run_scn("R6 refill after clear");

    // R2: single busy flow among empty ones, wraparound
    for (int i = 0; i < N; i++) set_q(i, 64);
    push(3, 64); push(3, 64);
    run_scn("R2 sparse wraparound");
    @(negedge clk);
    push(1, 10); push(2, 200); push(0, 64);
    run_scn("R2 search from last visited");

    // R9/R4: large quantum with many small packets beside a big one
    set_q(0, 300); set_q(2, 1000);
    for (int k = 0; k < 8; k++) push(2, 100 + k);
    push(0, 700); push(0, 5);
    run_scn("R9/R4 burst within one visit");

    // R7 again after traffic
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      if (c % 3 == 0) check_eq("R7", int'(deq_valid), 0, "deq_valid idle after traffic");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule